// File: doc/BRIEF.md
# Tagged Register Spill and Fill Unit

This block holds a small general register file in which every data register carries one extra bit, the deferred-fault tag. The tag marks a value that came from a speculative computation which would have faulted. Memory has no room for that bit. Instead, a 64-bit tag collection register holds the tags of registers saved to memory. The address bits just above the byte offset choose which of its bits is used.

A spill sends the full register value to a simple memory write port and drops its tag into the selected collection bit. A fill takes a word from a memory read port into a register and picks its tag back up from the same bit. Ordinary loads and stores move data without touching the collection register. Software reads and writes the collection register through a dedicated port so that it can save and restore it around a run of spills and fills.

One operation is presented per cycle. The memory ports are combinational in the operation's cycle, and register and collection updates land on the following clock edge. An observation port shows any register's value and tag.

Top module: `tagspill_unit`

## Requirements
- R1: With op_code 4 (spill) or op_code 3 (store), in the same cycle mem_wr_en is 1, mem_wr_addr equals op_addr and mem_wr_data equals the full value of register op_reg. The other operations leave mem_wr_en at 0.
- R2: A spill writes the tag of register op_reg into collection bit op_addr[8:3]. The new value appears on coll_rd_data after the next clock edge, and the other 63 bits keep their values.
- R3: With op_code 5 (fill), the word on mem_rd_data is written into register op_reg, and its tag is set to collection bit op_addr[8:3] as it stood before that edge. mem_rd_en is 1 and mem_rd_addr equals op_addr in that cycle.
- R4: A spill whose source tag is set stores the value unchanged and raises no error.
- R5: misalign_err is 1 in the same cycle exactly when a spill or fill has op_addr[2:0] nonzero. The operation still executes using bits 8:3 for the tag index.
- R6: When coll_wr_en is 1, coll_wr_data is loaded into the collection register on the clock edge. coll_rd_data always shows the current contents.
- R7: When coll_wr_en and a spill occur in the same cycle, the spill tag wins at bit op_addr[8:3], and all other bits take coll_wr_data.
- R8: op_code 2 (load) writes mem_rd_data into op_reg and clears its tag. Neither a load nor a store changes the collection register.
- R9: Register 0 always reads as zero with its tag clear, and writes to it are discarded.
- R10: op_code 1 (set) writes op_wdata and op_wtag into op_reg. op_code 0, 6 and 7 do nothing.
- R11: After reset all registers, all tags and the collection register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_code | input | 3 | Operation: 0 none, 1 set, 2 load, 3 store, 4 spill, 5 fill |
| op_reg | input | 3 | Register operand (source or destination) |
| op_addr | input | 16 | Byte address of the memory operand |
| op_wdata | input | 64 | Value for the set operation |
| op_wtag | input | 1 | Tag for the set operation |
| coll_wr_en | input | 1 | Software write of the collection register |
| coll_wr_data | input | 64 | Value for the software write |
| coll_rd_data | output | 64 | Current collection register contents |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 64 | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 64 | Memory read data, valid in the same cycle |
| obs_reg | input | 3 | Register selected for observation |
| obs_data | output | 64 | Value of the observed register |
| obs_tag | output | 1 | Tag of the observed register |
| misalign_err | output | 1 | Spill or fill address not 8-byte aligned |

## Verification
A wrong collection bit shows up on coll_rd_data one edge after the spill or software write that caused it. It shows up again at the next fill from that index, as a wrong obs_tag on the destination register. A corrupted register value shows up on mem_wr_data in the same cycle as a later spill or store from it, and on obs_data as soon as the register is selected. Sweeping every collection index for both spill and fill means an indexing slip cannot hide behind an unvisited bit. So does a bit that goes wrong because a neighbour was disturbed.

// File: rtl/tagspill_pkg.sv
`timescale 1ns/1ps
package tagspill_pkg;

   typedef enum logic [2:0] {
      TS_NOP   = 3'd0,
      TS_SET   = 3'd1,
      TS_LOAD  = 3'd2,
      TS_STORE = 3'd3,
      TS_SPILL = 3'd4,
      TS_FILL  = 3'd5
   } ts_op_e;

   typedef struct packed {
      logic set;
      logic load;
      logic store;
      logic spill;
      logic fill;
   } ts_strobe_t;

endpackage

// File: rtl/tagspill_decode.sv
`timescale 1ns/1ps
module tagspill_decode
   import tagspill_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_LO = 3,
   parameter int IDX_W  = 6
) (
   input  logic [2:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   output ts_strobe_t        strobe,
   output logic [IDX_W-1:0]  idx,
   output logic              misalign
);

   if (IDX_LO < 1) begin : g_bad_lo
      $error("IDX_LO must be at least 1");
   end
   if (ADDR_W < IDX_LO + IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the tag index field");
   end

   always_comb begin
      strobe = '0;
      case (op_code)
         TS_SET:   strobe.set   = 1'b1;
         TS_LOAD:  strobe.load  = 1'b1;
         TS_STORE: strobe.store = 1'b1;
         TS_SPILL: strobe.spill = 1'b1;
         TS_FILL:  strobe.fill  = 1'b1;
         default:  strobe = '0;
      endcase
   end

   assign idx      = op_addr[IDX_LO +: IDX_W];
   assign misalign = (strobe.spill | strobe.fill) & (|op_addr[IDX_LO-1:0]);

endmodule

// File: rtl/tagspill_regfile.sv
`timescale 1ns/1ps
module tagspill_regfile #(
   parameter int NREGS     = 8,
   parameter int DATA_W    = 64,
   parameter bit ZERO_REG0 = 1'b1,
   localparam int RAW      = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RAW-1:0]    waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wtag,
   input  logic [RAW-1:0]    raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   output logic              rtag_a,
   input  logic [RAW-1:0]    raddr_b,
   output logic [DATA_W-1:0] rdata_b,
   output logic              rtag_b
);

   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("NREGS must be a power of two, at least 2");
   end

   logic [NREGS-1:0][DATA_W-1:0] val_w;
   logic [NREGS-1:0]             tag_w;

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (g == 0 && ZERO_REG0) begin : g_hard_zero
         assign val_w[g] = '0;
         assign tag_w[g] = 1'b0;
      end else begin : g_store
         logic [DATA_W-1:0] q_val;
         logic              q_tag;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_val <= '0;
               q_tag <= 1'b0;
            end else if (we && waddr == RAW'(g)) begin
               q_val <= wdata;
               q_tag <= wtag;
            end
         end
         assign val_w[g] = q_val;
         assign tag_w[g] = q_tag;
      end
   end

   assign rdata_a = val_w[raddr_a];
   assign rtag_a  = tag_w[raddr_a];
   assign rdata_b = val_w[raddr_b];
   assign rtag_b  = tag_w[raddr_b];

   // R10 / R3 / R8: a write to a storing register lands with its value and tag
   p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (waddr != '0 || !ZERO_REG0)) |=>
         (val_w[$past(waddr)] == $past(wdata) && tag_w[$past(waddr)] == $past(wtag)));

   // R9: register 0 never changes when hardwired
   p_zero_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG0 && we && waddr == '0) |=> (val_w[0] == '0 && !tag_w[0]));

endmodule

// File: rtl/tagspill_collect.sv
`timescale 1ns/1ps
module tagspill_collect #(
   parameter int COLL_W = 64,
   localparam int IDX_W = $clog2(COLL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [COLL_W-1:0] sw_wdata,
   input  logic              sp_we,
   input  logic [IDX_W-1:0]  sp_idx,
   input  logic              sp_tag,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [COLL_W-1:0] q,
   output logic              rd_bit
);

   if (COLL_W < 2 || (COLL_W & (COLL_W - 1)) != 0) begin : g_bad_coll
      $error("COLL_W must be a power of two, at least 2");
   end

   for (genvar b = 0; b < COLL_W; b++) begin : g_bit
      logic hit;
      assign hit = sp_we && (sp_idx == IDX_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[b] <= 1'b0;
         else if (hit)    q[b] <= sp_tag;
         else if (sw_we)  q[b] <= sw_wdata[b];
      end
   end

   assign rd_bit = q[rd_idx];

   // R2: the addressed bit takes the spilled tag
   p_spill_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sp_we |=> (q[$past(sp_idx)] == $past(sp_tag)));

   // R2: without a software write, a spill disturbs no other bit
   p_spill_only_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_we && !sw_we) |=>
         (((q ^ $past(q)) & ~(COLL_W'(1) << $past(sp_idx))) == '0));

   // R8 / R6: no spill and no software write leaves the register stable
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_we && !sw_we) |=> $stable(q));

   // R6: a lone software write loads the whole register
   p_sw_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !sp_we) |=> (q == $past(sw_wdata)));

   // R7: on a collision the other bits come from the software value
   p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && sp_we) |=>
         ((q & ~(COLL_W'(1) << $past(sp_idx))) ==
          ($past(sw_wdata) & ~(COLL_W'(1) << $past(sp_idx)))));

endmodule

// File: rtl/tagspill_unit.sv
`timescale 1ns/1ps
module tagspill_unit
   import tagspill_pkg::*;
#(
   parameter int NREGS     = 8,
   parameter int DATA_W    = 64,
   parameter int ADDR_W    = 16,
   parameter int COLL_W    = 64,
   parameter bit ZERO_REG0 = 1'b1,
   localparam int RAW      = $clog2(NREGS),
   localparam int IDX_W    = $clog2(COLL_W),
   localparam int IDX_LO   = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_code,
   input  logic [RAW-1:0]    op_reg,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic              op_wtag,
   input  logic              coll_wr_en,
   input  logic [COLL_W-1:0] coll_wr_data,
   output logic [COLL_W-1:0] coll_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [DATA_W-1:0] mem_rd_data,
   input  logic [RAW-1:0]    obs_reg,
   output logic [DATA_W-1:0] obs_data,
   output logic              obs_tag,
   output logic              misalign_err
);

   if (DATA_W < 16 || (DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power-of-two byte multiple, at least 16");
   end

   ts_strobe_t        st;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] src_val;
   logic              src_tag;
   logic              coll_bit;
   logic              rf_we;
   logic [DATA_W-1:0] rf_wdata;
   logic              rf_wtag;

   tagspill_decode #(
      .ADDR_W (ADDR_W),
      .IDX_LO (IDX_LO),
      .IDX_W  (IDX_W)
   ) u_decode (
      .op_code  (op_code),
      .op_addr  (op_addr),
      .strobe   (st),
      .idx      (idx),
      .misalign (misalign_err)
   );

   always_comb begin
      rf_we    = st.set | st.load | st.fill;
      rf_wdata = st.set ? op_wdata : mem_rd_data;
      rf_wtag  = st.set ? op_wtag : (st.fill ? coll_bit : 1'b0);
   end

   tagspill_regfile #(
      .NREGS     (NREGS),
      .DATA_W    (DATA_W),
      .ZERO_REG0 (ZERO_REG0)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (op_reg),
      .wdata   (rf_wdata),
      .wtag    (rf_wtag),
      .raddr_a (op_reg),
      .rdata_a (src_val),
      .rtag_a  (src_tag),
      .raddr_b (obs_reg),
      .rdata_b (obs_data),
      .rtag_b  (obs_tag)
   );

   tagspill_collect #(
      .COLL_W (COLL_W)
   ) u_coll (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (coll_wr_en),
      .sw_wdata (coll_wr_data),
      .sp_we    (st.spill),
      .sp_idx   (idx),
      .sp_tag   (src_tag),
      .rd_idx   (idx),
      .q        (coll_rd_data),
      .rd_bit   (coll_bit)
   );

   assign mem_wr_en   = st.store | st.spill;
   assign mem_wr_addr = op_addr;
   assign mem_wr_data = src_val;
   assign mem_rd_en   = st.load | st.fill;
   assign mem_rd_addr = op_addr;

   // R1: spill opcode at the port drives the memory write
   p_spill_writes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == TS_SPILL) |-> (mem_wr_en && mem_wr_addr == op_addr));

   // R3: fill opcode at the port drives the memory read
   p_fill_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == TS_FILL) |-> (mem_rd_en && !mem_wr_en));

   // R5: the alignment flag only rises for spill or fill
   p_misalign_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_err |-> (op_code == TS_SPILL || op_code == TS_FILL));

   // R9: observing register 0 shows zero
   p_obs_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG0 && obs_reg == '0) |-> (obs_data == '0 && !obs_tag));

endmodule

// File: tb/tagspill_unit_bench.sv
`timescale 1ns/1ps
module tagspill_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic [2:0]  op_reg = 3'd0;
   logic [15:0] op_addr = 16'd0;
   logic [63:0] op_wdata = 64'd0;
   logic        op_wtag = 1'b0;
   logic        coll_wr_en = 1'b0;
   logic [63:0] coll_wr_data = 64'd0;
   logic [63:0] coll_rd_data;
   logic        mem_wr_en;
   logic [15:0] mem_wr_addr;
   logic [63:0] mem_wr_data;
   logic        mem_rd_en;
   logic [15:0] mem_rd_addr;
   logic [63:0] mem_rd_data;
   logic [2:0]  obs_reg = 3'd0;
   logic [63:0] obs_data;
   logic        obs_tag;
   logic        misalign_err;

   int n_vec = 0;
   int n_bad = 0;

   logic [63:0] bmem  [128];
   logic [63:0] e_mem [128];
   logic [63:0] m_val [8];
   logic        m_tag [8];
   logic [63:0] m_coll;

   always #4 clk = ~clk;

   tagspill_unit u_tagspill_unit (
      .clk (clk), .rst_n (rst_n),
      .op_code (op_code), .op_reg (op_reg), .op_addr (op_addr),
      .op_wdata (op_wdata), .op_wtag (op_wtag),
      .coll_wr_en (coll_wr_en), .coll_wr_data (coll_wr_data),
      .coll_rd_data (coll_rd_data),
      .mem_wr_en (mem_wr_en), .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data),
      .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr), .mem_rd_data (mem_rd_data),
      .obs_reg (obs_reg), .obs_data (obs_data), .obs_tag (obs_tag),
      .misalign_err (misalign_err)
   );

   assign mem_rd_data = bmem[mem_rd_addr[9:3]];
   always @(posedge clk) if (mem_wr_en) bmem[mem_wr_addr[9:3]] <= mem_wr_data;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   task automatic issue(input int op, input int r, input logic [15:0] a,
                        input logic [63:0] d, input logic t,
                        input logic cwe, input logic [63:0] cwd);
      logic [63:0] nc;
      int w, ix;
      @(negedge clk);
      op_code = op[2:0]; op_reg = r[2:0]; op_addr = a; op_wdata = d; op_wtag = t;
      coll_wr_en = cwe; coll_wr_data = cwd;
      #2;
      w  = int'(a[9:3]);
      ix = int'(a[8:3]);
      chk("R5 misalign flag", misalign_err, ((op == 4 || op == 5) && a[2:0] != 0));
      if (op == 3 || op == 4) begin
         chk("R1 write strobe", mem_wr_en, 1);
         chk("R1 write addr", mem_wr_addr, a);
         chk("R1/R4 write data", mem_wr_data, m_val[r]);
      end else begin
         chk("R1 no write", mem_wr_en, 0);
      end
      if (op == 2 || op == 5) begin
         chk("R3 read strobe", mem_rd_en, 1);
         chk("R3 read addr", mem_rd_addr, a);
      end
      nc = cwe ? cwd : m_coll;
      if (op == 4) nc[ix] = m_tag[r];
      case (op)
         1: if (r != 0) begin m_val[r] = d; m_tag[r] = t; end
         2: if (r != 0) begin m_val[r] = e_mem[w]; m_tag[r] = 1'b0; end
         3, 4: e_mem[w] = m_val[r];
         5: if (r != 0) begin m_val[r] = e_mem[w]; m_tag[r] = m_coll[ix]; end
         default: ;
      endcase
      m_coll = nc;
      @(posedge clk);
   endtask

   task automatic idle();
      @(negedge clk);
      op_code = 3'd0; coll_wr_en = 1'b0;
   endtask

   task automatic peek(input int r, input string what);
      @(negedge clk);
      op_code = 3'd0; coll_wr_en = 1'b0; obs_reg = r[2:0];
      #2;
      chk({what, " value"}, obs_data, m_val[r]);
      chk({what, " tag"}, obs_tag, m_tag[r]);
      chk({what, " collection"}, coll_rd_data, m_coll);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      for (int i = 0; i < 128; i++) begin
         bmem[i]  = 64'h0F1E_2D3C_0000_0000 ^ (64'(i) * 64'h0001_0003_0007_000B);
         e_mem[i] = bmem[i];
      end
      for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_tag[i] = 1'b0; end
      m_coll = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R11: reset state
      for (int r = 0; r < 8; r++) peek(r, "R11 reset");

      // R10: set every register, odd ones tagged; R9: set on register 0 discarded
      for (int r = 0; r < 8; r++)
         issue(1, r, 16'h0005, 64'hA5A5_0000_0000_0000 ^ (64'(r) * 64'h0101_0101_0101_0101), r[0], 1'b0, '0);
      for (int r = 0; r < 8; r++) peek(r, "R10/R9 set");

      // R2/R4/R5: spill sweep over all collection indices, some misaligned
      for (int i = 0; i < 64; i++) begin
         logic [15:0] a;
         a = 16'(i * 8) | ((i % 4 == 3) ? 16'(i % 8) : 16'd0);
         issue(4, (i % 7) + 1, a, '0, 1'b0, 1'b0, '0);
         peek((i % 7) + 1, "R2 spill sweep");
      end

      // R6: software write then readback
      issue(0, 0, 16'd0, '0, 1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567);
      peek(1, "R6 software write");

      // R3/R5: fill sweep from the upper memory half, tags from every index
      for (int i = 0; i < 64; i++) begin
         logic [15:0] a;
         a = 16'h0200 | 16'(i * 8) | ((i % 5 == 1) ? 16'd6 : 16'd0);
         issue(5, (i % 7) + 1, a, '0, 1'b0, 1'b0, '0);
         peek((i % 7) + 1, "R3 fill sweep");
      end

      // R7: software write colliding with spill
      issue(1, 3, 16'd0, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, '0);
      for (int k = 0; k < 4; k++) begin
         issue(4, 3, 16'(k * 136), '0, 1'b0, 1'b1, (k[0] ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0));
         peek(3, "R7 collision");
      end
      issue(1, 3, 16'd0, 64'h0, 1'b0, 1'b0, '0);
      issue(4, 3, 16'h01F8, '0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      peek(3, "R7 collision clear");

      // R8: ordinary store of a tagged register and load clearing a tag
      issue(1, 5, 16'd0, 64'hCAFE_F00D_0000_0001, 1'b1, 1'b0, '0);
      issue(3, 5, 16'h0038, '0, 1'b0, 1'b0, '0);
      peek(5, "R8 store");
      issue(2, 5, 16'h0038, '0, 1'b0, 1'b0, '0);
      peek(5, "R8 load");
      issue(2, 6, 16'h0210, '0, 1'b0, 1'b0, '0);
      peek(6, "R8 load other");

      // R9: fill and load into register 0, spill of register 0
      issue(5, 0, 16'h0208, '0, 1'b0, 1'b0, '0);
      peek(0, "R9 fill r0");
      issue(2, 0, 16'h0208, '0, 1'b0, 1'b0, '0);
      peek(0, "R9 load r0");
      issue(1, 0, 16'd0, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b0, '0);
      peek(0, "R9 set r0");
      issue(0, 0, 16'd0, '0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      issue(4, 0, 16'h0010, '0, 1'b0, 1'b0, '0);
      peek(0, "R9 spill r0");

      // R10: unused opcodes do nothing
      issue(6, 2, 16'h0010, 64'h1, 1'b1, 1'b0, '0);
      issue(7, 2, 16'h0011, 64'h1, 1'b1, 1'b0, '0);
      peek(2, "R10 unused opcodes");

      // R4: tagged spill data round trip through fill
      issue(1, 7, 16'd0, 64'h7777_8888_9999_AAAA, 1'b1, 1'b0, '0);
      issue(4, 7, 16'h0100, '0, 1'b0, 1'b0, '0);
      issue(1, 7, 16'd0, 64'h0, 1'b0, 1'b0, '0);
      issue(5, 7, 16'h0100, '0, 1'b0, 1'b0, '0);
      peek(7, "R4 round trip");

      idle();
      summary();
   end

endmodule